// File: doc/BRIEF.md
# Cipher Data FIFO Pair with Block-Start Gating

This block buffers the data path of a block-cipher accelerator. Software pushes 32-bit words into an eight-word input queue and pulls results out of an eight-word output queue. A start controller passes one whole block to the cipher core over a valid/ready handoff. It does so only when the input queue holds a complete block and the output queue has free space for a complete result. A block is two words in narrow (64-bit) mode and four words in wide (128-bit) mode.

The core returns its result through a single strobe, and those words are appended to the output queue. A busy flag covers the time from handoff until the result lands. While the unit is disabled, software can inspect the input queue by reading the data-in port, which pops words oldest first. A flush control empties both queues in one cycle, and must be used after such an inspection before new data is processed.

Top module: `cipher_fifo_pair`

## Requirements
- R1: Each cycle with `dinWrite` high appends `dinWdata` to the input queue (depth 8). A write to a full queue is dropped. `inEmpty` is high when the queue holds 0 words and `inFull` is high when it holds 8. After reset both queues are empty and `busy` is low.
- R2: `coreValid` is high only when `enable` is high, `busy` is low, no flush is taking effect, and the input queue holds at least the block size. The block size is 4 words when `wideMode`=1 and 2 words when `wideMode`=0.
- R3: `coreValid` also requires the output queue to have at least the block size in free entries, that is 8 minus its occupancy.
- R4: `coreBlock` carries the oldest input word in bits 31:0, the next in 63:32, and so on. In narrow mode bits 127:64 are zero. A cycle with `coreValid` and `coreReady` both high removes one block from the input queue.
- R5: `busy` rises in the cycle after a handoff and stays high until the cycle after the result strobe. `coreValid` is low while `busy` is high.
- R6: `resultValid` while busy appends 2 or 4 words from `resultBlock`, bits 31:0 first. The count follows the mode captured at handoff, not the current `wideMode`. `resultValid` while not busy has no effect.
- R7: `doutRdata` shows the oldest output word in the same cycle as `doutRead`, and the read pops that word. When the output queue is empty, `doutRdata` is zero and a read changes nothing.
- R8: With `enable` low, `dinRdata` shows the oldest input word and `dinRead` pops it. An empty queue returns zero.
- R9: With `enable` high, `dinRdata` is zero and `dinRead` leaves the input queue unchanged.
- R10: `flush` empties both queues by the next cycle and wins over a write or read in the same cycle. `flush` is ignored while `busy` is high.
- R11: A push and a pop on the same queue in one cycle both take effect. This covers a software write together with a handoff, and a software output read together with a result strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit enable; low allows input read-back |
| wideMode | input | 1 | 1 selects 4-word blocks, 0 selects 2-word blocks |
| flush | input | 1 | Empty both queues (ignored while busy) |
| dinWrite | input | 1 | Push `dinWdata` into the input queue |
| dinWdata | input | 32 | Input word |
| dinRead | input | 1 | Read-back pop of the input queue |
| dinRdata | output | 32 | Read-back data |
| doutRead | input | 1 | Pop the output queue |
| doutRdata | output | 32 | Oldest output word |
| inEmpty | output | 1 | Input queue holds no words |
| inFull | output | 1 | Input queue holds 8 words |
| outEmpty | output | 1 | Output queue holds no words |
| busy | output | 1 | Block handed off, result pending |
| coreValid | output | 1 | Block offered to the core |
| coreReady | input | 1 | Core accepts the offered block |
| coreBlock | output | 128 | Offered block, oldest word lowest |
| resultValid | input | 1 | Core result strobe |
| resultBlock | input | 128 | Core result, first word lowest |

## Verification
Two pairs of events can fall in one cycle. A software write can arrive on the same edge as a block handoff, and a software output read can arrive on the same edge as the result strobe; each pair moves both pointers of one queue together. The bench provokes both on purpose. It holds the output queue just short of the room a wide block needs, drains it word by word until the start condition appears, and then strobes the result together with a read. A queue-based reference model checks occupancy, flags and head data on every cycle, so a lost push or a doubled pop is seen at once.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  // Per-cycle actions decided by the control and carried out by the datapath.
  typedef struct packed {
    logic pushIn;       // software word enters the input queue
    logic readBack;     // disabled-mode pop of the input queue
    logic handoff;      // one block leaves the input queue for the core
    logic handoffWide;  // block size of a handoff this cycle is wide
    logic pushOut;      // core result enters the output queue
    logic pushWide;     // result is a wide block
    logic popOut;       // software pops the output queue
    logic clear;        // flush both queues
  } cfpStrobes_t;

endpackage

// File: rtl/cfp_fifo.sv
module cfp_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int MAXN   = 4,
  parameter int HEAD_N = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clear,
  input  logic [CNT_W-1:0]         pushCnt,
  input  logic [MAXN*DATA_W-1:0]   pushData,
  input  logic [CNT_W-1:0]         popCnt,
  output logic [CNT_W-1:0]         count,
  output logic [HEAD_N*DATA_W-1:0] headData
);

  // DEPTH is a power of two so the pointers wrap naturally.
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else if (clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      wrPtr <= wrPtr + pushCnt[PTR_W-1:0];
      rdPtr <= rdPtr + popCnt[PTR_W-1:0];
      cnt   <= cnt + pushCnt - popCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      for (int i = 0; i < MAXN; i++) begin
        if (CNT_W'(i) < pushCnt) mem[wrPtr + PTR_W'(i)] <= pushData[i*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < HEAD_N; i++) headData[i*DATA_W +: DATA_W] = mem[rdPtr + PTR_W'(i)];
  end

  assign count = cnt;

  // R3 (and R1): the control never pushes more words than there is room for
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    !clear |-> ({1'b0, pushCnt} <= ((CNT_W+1)'(DEPTH) - {1'b0, cnt} + {1'b0, popCnt})));

  // R8: the control never pops words that are not present
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    !clear |-> (popCnt <= cnt));

endmodule

// File: rtl/cfp_control.sv
module cfp_control
  import cfp_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int NARROW_WORDS = 2,
  parameter int WIDE_WORDS   = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wideMode,
  input  logic             flush,
  input  logic             dinWrite,
  input  logic             dinRead,
  input  logic             doutRead,
  input  logic             coreReady,
  input  logic             resultValid,
  input  logic [CNT_W-1:0] inCount,
  input  logic [CNT_W-1:0] outCount,
  output cfpStrobes_t      strobes,
  output logic             coreValid,
  output logic             busy
);

  localparam logic [CNT_W-1:0] NARROW_N = CNT_W'(NARROW_WORDS);
  localparam logic [CNT_W-1:0] WIDE_N   = CNT_W'(WIDE_WORDS);
  localparam logic [CNT_W-1:0] FULL_N   = CNT_W'(DEPTH);

  logic             busyQ, busyWideQ;
  logic [CNT_W-1:0] blkWords, outFree;
  logic             flushNow, startOk;

  always_comb begin
    blkWords = wideMode ? WIDE_N : NARROW_N;
    outFree  = FULL_N - outCount;
    flushNow = flush && !busyQ;
    startOk  = enable && !busyQ && !flushNow &&
               (inCount >= blkWords) && (outFree >= blkWords);

    strobes.clear       = flushNow;
    strobes.handoff     = startOk && coreReady;
    strobes.handoffWide = wideMode;
    strobes.pushIn      = dinWrite && !flushNow && (inCount != FULL_N);
    strobes.readBack    = dinRead && !enable && !flushNow && (inCount != '0);
    strobes.popOut      = doutRead && !flushNow && (outCount != '0);
    strobes.pushOut     = resultValid && busyQ;
    strobes.pushWide    = busyWideQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      busyWideQ <= 1'b0;
    end else if (strobes.handoff) begin
      busyQ     <= 1'b1;
      busyWideQ <= wideMode;
    end else if (strobes.pushOut) begin
      busyQ     <= 1'b0;
    end
  end

  assign coreValid = startOk;
  assign busy      = busyQ;

  // R5: a handoff always leaves the unit busy in the next cycle
  assert_handoff_sets_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && coreReady) |=> busy);

  // R5: busy holds until the core strobes its result
  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !resultValid) |=> busy);

  // R10: a flush request while busy is not acted on
  assert_flush_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.clear);

endmodule

// File: rtl/cfp_datapath.sv
module cfp_datapath
  import cfp_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 8,
  parameter int NARROW_WORDS = 2,
  parameter int WIDE_WORDS   = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BLK_W = DATA_W * WIDE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  cfpStrobes_t       strobes,
  input  logic [DATA_W-1:0] dinWdata,
  input  logic [BLK_W-1:0]  resultBlock,
  output logic [CNT_W-1:0]  inCount,
  output logic [CNT_W-1:0]  outCount,
  output logic [DATA_W-1:0] dinRdata,
  output logic [DATA_W-1:0] doutRdata,
  output logic [BLK_W-1:0]  coreBlock
);

  localparam logic [CNT_W-1:0] NARROW_N = CNT_W'(NARROW_WORDS);
  localparam logic [CNT_W-1:0] WIDE_N   = CNT_W'(WIDE_WORDS);
  localparam logic [CNT_W-1:0] ONE_N    = CNT_W'(1);

  logic [CNT_W-1:0]  inPushCnt, inPopCnt, outPushCnt, outPopCnt;
  logic [BLK_W-1:0]  inPushData, inHead;
  logic [DATA_W-1:0] outHead;

  always_comb begin
    inPushCnt  = strobes.pushIn ? ONE_N : '0;
    inPushData = {{(BLK_W-DATA_W){1'b0}}, dinWdata};
    if (strobes.handoff)       inPopCnt = strobes.handoffWide ? WIDE_N : NARROW_N;
    else if (strobes.readBack) inPopCnt = ONE_N;
    else                       inPopCnt = '0;
    outPushCnt = strobes.pushOut ? (strobes.pushWide ? WIDE_N : NARROW_N) : '0;
    outPopCnt  = strobes.popOut ? ONE_N : '0;
  end

  cfp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAXN(WIDE_WORDS), .HEAD_N(WIDE_WORDS)) u_inFifo (
    .clk(clk), .rstN(rstN), .clear(strobes.clear),
    .pushCnt(inPushCnt), .pushData(inPushData), .popCnt(inPopCnt),
    .count(inCount), .headData(inHead)
  );

  cfp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAXN(WIDE_WORDS), .HEAD_N(1)) u_outFifo (
    .clk(clk), .rstN(rstN), .clear(strobes.clear),
    .pushCnt(outPushCnt), .pushData(resultBlock), .popCnt(outPopCnt),
    .count(outCount), .headData(outHead)
  );

  // Block packing: words past the narrow size are zeroed in narrow mode.
  for (genvar g = 0; g < WIDE_WORDS; g++) begin : gBlkWord
    if (g < NARROW_WORDS) begin : gAlways
      assign coreBlock[g*DATA_W +: DATA_W] = inHead[g*DATA_W +: DATA_W];
    end else begin : gWideOnly
      assign coreBlock[g*DATA_W +: DATA_W] =
        strobes.handoffWide ? inHead[g*DATA_W +: DATA_W] : '0;
    end
  end

  assign dinRdata  = (!enable && inCount != '0) ? inHead[DATA_W-1:0] : '0;
  assign doutRdata = (outCount != '0) ? outHead : '0;

  // R10: a flush that takes effect leaves both queues empty
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (inCount == '0 && outCount == '0));

  // R9: read-back pops are only issued while the unit is disabled
  assert_readback_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readBack |-> !enable);

  // R9: when enabled and nothing else moves the input queue, its count is stable
  assert_enabled_read_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strobes.pushIn && !strobes.handoff && !strobes.clear) |=> $stable(inCount));

endmodule

// File: rtl/cipher_fifo_pair.sv
module cipher_fifo_pair
  import cfp_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 8,
  parameter int NARROW_WORDS = 2,
  parameter int WIDE_WORDS   = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BLK_W = DATA_W * WIDE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              wideMode,
  input  logic              flush,
  input  logic              dinWrite,
  input  logic [DATA_W-1:0] dinWdata,
  input  logic              dinRead,
  output logic [DATA_W-1:0] dinRdata,
  input  logic              doutRead,
  output logic [DATA_W-1:0] doutRdata,
  output logic              inEmpty,
  output logic              inFull,
  output logic              outEmpty,
  output logic              busy,
  output logic              coreValid,
  input  logic              coreReady,
  output logic [BLK_W-1:0]  coreBlock,
  input  logic              resultValid,
  input  logic [BLK_W-1:0]  resultBlock
);

  cfpStrobes_t      strobes;
  logic [CNT_W-1:0] inCount, outCount;

  cfp_control #(.DEPTH(DEPTH), .NARROW_WORDS(NARROW_WORDS), .WIDE_WORDS(WIDE_WORDS)) u_control (
    .clk(clk), .rstN(rstN), .enable(enable), .wideMode(wideMode), .flush(flush),
    .dinWrite(dinWrite), .dinRead(dinRead), .doutRead(doutRead),
    .coreReady(coreReady), .resultValid(resultValid),
    .inCount(inCount), .outCount(outCount),
    .strobes(strobes), .coreValid(coreValid), .busy(busy)
  );

  cfp_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NARROW_WORDS(NARROW_WORDS),
                 .WIDE_WORDS(WIDE_WORDS)) u_datapath (
    .clk(clk), .rstN(rstN), .enable(enable), .strobes(strobes),
    .dinWdata(dinWdata), .resultBlock(resultBlock),
    .inCount(inCount), .outCount(outCount),
    .dinRdata(dinRdata), .doutRdata(doutRdata), .coreBlock(coreBlock)
  );

  assign inEmpty  = (inCount == '0);
  assign inFull   = (inCount == CNT_W'(DEPTH));
  assign outEmpty = (outCount == '0);

endmodule

// File: tb/cipher_fifo_pair_tb.sv
module cipher_fifo_pair_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0, wideMode = 1'b0, flush = 1'b0;
  logic         dinWrite = 1'b0, dinRead = 1'b0, doutRead = 1'b0;
  logic         coreReady = 1'b0, resultValid = 1'b0;
  logic [31:0]  dinWdata = '0;
  logic [127:0] resultBlock = '0;
  logic [31:0]  dinRdata, doutRdata;
  logic [127:0] coreBlock;
  logic         inEmpty, inFull, outEmpty, busy, coreValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_fifo_pair u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .wideMode(wideMode), .flush(flush),
    .dinWrite(dinWrite), .dinWdata(dinWdata), .dinRead(dinRead), .dinRdata(dinRdata),
    .doutRead(doutRead), .doutRdata(doutRdata), .inEmpty(inEmpty), .inFull(inFull),
    .outEmpty(outEmpty), .busy(busy), .coreValid(coreValid), .coreReady(coreReady),
    .coreBlock(coreBlock), .resultValid(resultValid), .resultBlock(resultBlock)
  );

  int          checks = 0, errors = 0;
  int          patCnt = 0;
  string       phase = "R1 reset";
  logic [31:0] inQ[$], outQ[$];
  bit          mBusy = 0, mBusyWide = 0;

  task automatic chk(string sig, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL [%s] %s: actual %0h expected %0h", phase, sig, act, exp);
    end
  endtask

  // One clock cycle: drive, compare with the model, advance the model.
  task automatic cyc(bit w = 0, logic [31:0] wd = 0, bit ri = 0, bit ro = 0,
                     bit fl = 0, bit rdy = 0, bit rv = 0);
    int           blk, inSz, outSz;
    bit           flushNow, startOk, handoff, rb, po, pi, pu;
    logic [127:0] expBlk;
    dinWrite = w; dinWdata = wd; dinRead = ri; doutRead = ro;
    flush = fl; coreReady = rdy; resultValid = rv;
    resultBlock = {32'(patCnt + 3), 32'(patCnt + 2), 32'(patCnt + 1), 32'(patCnt)} ^ {4{32'h5A00_0000}};
    patCnt += 16;
    #1;
    blk      = wideMode ? 4 : 2;
    inSz     = inQ.size();
    outSz    = outQ.size();
    flushNow = fl && !mBusy;
    startOk  = enable && !mBusy && !flushNow && inSz >= blk && (DEPTH - outSz) >= blk;
    chk("inEmpty(R1)", inEmpty, inSz == 0);
    chk("inFull(R1)", inFull, inSz == DEPTH);
    chk("outEmpty(R7)", outEmpty, outSz == 0);
    chk("busy(R5)", busy, mBusy);
    chk("coreValid(R2 R3)", coreValid, startOk);
    if (startOk) begin
      expBlk = '0;
      for (int i = 0; i < blk; i++) expBlk[i*32 +: 32] = inQ[i];
      chk("coreBlock(R4)", coreBlock, expBlk);
    end
    chk("dinRdata(R8 R9)", dinRdata, (!enable && inSz > 0) ? inQ[0] : 32'h0);
    chk("doutRdata(R7)", doutRdata, (outSz > 0) ? outQ[0] : 32'h0);
    @(posedge clk);
    if (flushNow) begin
      inQ.delete();
      outQ.delete();
    end else begin
      handoff = startOk && rdy;
      rb = ri && !enable && inSz > 0;
      po = ro && outSz > 0;
      pi = w && inSz < DEPTH;
      pu = rv && mBusy;
      if (handoff) repeat (blk) void'(inQ.pop_front());
      if (rb) void'(inQ.pop_front());
      if (pi) inQ.push_back(wd);
      if (po) void'(outQ.pop_front());
      if (pu) for (int i = 0; i < (mBusyWide ? 4 : 2); i++) outQ.push_back(resultBlock[i*32 +: 32]);
      if (handoff) begin
        mBusy = 1; mBusyWide = wideMode;
      end else if (pu) begin
        mBusy = 0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    phase = "R1 reset state";
    cyc();

    phase = "R1 fill input, ninth write dropped";
    for (int i = 0; i < 9; i++) cyc(.w(1), .wd(32'hA000_0000 + 32'(i)));

    phase = "R8 read back oldest first";
    for (int i = 0; i < 3; i++) cyc(.ri(1));
    phase = "R8 R11 write during read back";
    cyc(.w(1), .wd(32'hB000_0001), .ri(1));

    phase = "R10 flush wins over write";
    cyc(.w(1), .wd(32'hB000_0002), .fl(1));
    cyc();
    phase = "R8 empty read back";
    cyc(.ri(1));

    phase = "R9 enabled read leaves queue";
    enable = 1'b1; wideMode = 1'b0;
    cyc(.w(1), .wd(32'hC000_0001));
    cyc(.ri(1));
    cyc(.ri(1), .w(1), .wd(32'hC000_0002));
    phase = "R2 block offered without ready";
    cyc(); cyc();
    phase = "R11 write with handoff";
    cyc(.w(1), .wd(32'hC000_0003), .rdy(1));
    phase = "R10 flush ignored while busy";
    cyc(.fl(1)); cyc();
    phase = "R6 narrow result push";
    cyc(.rv(1));
    phase = "R6 result ignored when idle";
    cyc(.rv(1));
    phase = "R7 drain output and empty read";
    for (int i = 0; i < 4; i++) cyc(.ro(1));

    phase = "R10 flush while enabled";
    cyc(.fl(1));

    phase = "R3 narrow blocks fill output to six";
    for (int k = 0; k < 3; k++) begin
      cyc(.w(1), .wd(32'hD000_0000 + 32'(2*k)));
      cyc(.w(1), .wd(32'hD000_0001 + 32'(2*k)));
      cyc(.rdy(1));
      cyc(.rv(1));
    end

    phase = "R3 wide block waits for output room";
    wideMode = 1'b1;
    for (int i = 0; i < 4; i++) cyc(.w(1), .wd(32'hE000_0000 + 32'(i)), .rdy(1));
    cyc(.ro(1), .rdy(0));
    cyc(.ro(1));
    phase = "R4 wide block handoff";
    cyc(.rdy(1));
    phase = "R6 R11 result with output read, mode changed";
    wideMode = 1'b0;
    cyc(.rv(1), .ro(1));
    phase = "R7 drain after wide result";
    for (int i = 0; i < 8; i++) cyc(.ro(1));

    phase = "R9 disable and read back";
    enable = 1'b0;
    cyc(.w(1), .wd(32'hF000_0001));
    cyc(.ri(1));
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL [watchdog] run did not finish: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule